// File: doc/BRIEF.md
# Timestamped Write Queue Drain

This block holds the words that a host writes through the data port of a video controller until the controller reaches an external memory access slot. Each queued word carries the cycle count from which it may be released. On a slot that the transfer engine does not claim, the oldest word is released once its cycle count has been reached. It is written to one of three targets: the byte-wide pattern memory, the palette memory or the scroll memory. The target depends on the current command code. The write address then advances by the programmed step.

A word bound for the pattern memory is written as two bytes over two slots. The high byte goes first to the current address. The low byte follows to the address with bit 0 inverted. The word stays at the head of the queue between the two halves. When transfers are enabled and the command requests one, the released word is not written anywhere. It is kept as the fill value and a start pulse goes to the transfer engine. A slot that finds no word ready raises an idle indication. A writer that pushes into a full queue sees a wait signal, and that push is dropped.

Top module: `wq_drain`

## Requirements
- R1: After reset the queue is empty, `wr_wait` is low, `addr` is 0, `fill_value` is 0 and no memory write is issued.
- R2: The queue holds DEPTH (4) words. `wr_wait` is high exactly when all four are occupied, and a push made while `wr_wait` is high is dropped.
- R3: A slot (`slot` high, `dma_busy` low) serves the head word only if the queue is not empty and the word's timestamp is less than or equal to `cycle_now`. Otherwise `idle_slot` is high in that cycle and nothing else happens.
- R4: With `cmd_tgt` = 1 (pattern memory), the first slot writes the high byte of the head word to `addr` with `wr_target` = 0, without advancing `addr` or removing the word. The next serving slot writes the low byte to `addr` with bit 0 inverted. Both bytes sit in `wr_data[7:0]`.
- R5: With `cmd_tgt` = 3 (palette), one slot writes the whole word with `wr_target` = 1 at index (`addr` >> 1) mod 64.
- R6: With `cmd_tgt` = 5 (scroll), one slot writes the word with `wr_target` = 2 at index (`addr` >> 1) mod 64. The write is issued only when that index is below 40. Otherwise no write is issued, but the word is still removed and `addr` still advances.
- R7: After each completed write, `addr` grows by `autoinc` modulo 2^16 and the head word is removed, so words leave in push order. Any other `cmd_tgt` value removes the word and advances `addr` without a write.
- R8: When `dma_en` and `cmd_dma` are high, a served word produces a one-cycle `fill_start`. It becomes `fill_value` from the next cycle and is removed, with no memory write and no change of `addr`.
- R9: A slot with `dma_busy` high belongs to the transfer engine. It writes nothing, removes nothing, and raises neither `idle_slot` nor `fill_start`.
- R10: `addr_ld` loads `addr_in` into `addr` at the next edge, taking priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_now | input | 16 | Current cycle count |
| push | input | 1 | Queue a word |
| push_data | input | 16 | Word to queue |
| push_when | input | 16 | Cycle count from which the word may be released |
| wr_wait | output | 1 | Queue full; pushes are dropped |
| slot | input | 1 | External access slot in this cycle |
| dma_busy | input | 1 | Transfer engine owns the slot |
| dma_en | input | 1 | Transfers enabled |
| cmd_tgt | input | 4 | Target code: 1 pattern, 3 palette, 5 scroll |
| cmd_dma | input | 1 | Command requests a transfer |
| autoinc | input | 8 | Address step |
| addr_ld | input | 1 | Load the address register |
| addr_in | input | 16 | Value to load |
| addr | output | 16 | Current write address |
| wr_en | output | 1 | Memory write strobe |
| wr_target | output | 2 | 0 pattern, 1 palette, 2 scroll |
| wr_addr | output | 16 | Byte address or word index |
| wr_data | output | 16 | Write data |
| idle_slot | output | 1 | Slot found no ready word |
| fill_start | output | 1 | Released word starts a fill |
| fill_value | output | 16 | Last captured fill word |

## Verification
A lost or stuck half-word flag shows up within one or two slots: a byte goes to the wrong half of the address, a byte is written twice, or `addr` advances early. A wrong occupancy count shows up either as `wr_wait` at the wrong level in the same cycle, or as words that are skipped, repeated or out of order on `wr_data` when the queue drains. Timestamp errors appear as writes issued while `idle_slot` should be high. The bench compares every output in every cycle with a model queue, so any of these faults is reported in the first cycle it reaches the ports.

// File: rtl/wq_drain.sv
module wq_drain #(
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int AW          = 16,
  parameter int INCW        = 8,
  parameter int DEPTH       = 4,
  parameter int CRAM_WORDS  = 64,
  parameter int VSRAM_WORDS = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cycle_now,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic [CW-1:0]   push_when,
  output logic            wr_wait,
  input  logic            slot,
  input  logic            dma_busy,
  input  logic            dma_en,
  input  logic [3:0]      cmd_tgt,
  input  logic            cmd_dma,
  input  logic [INCW-1:0] autoinc,
  input  logic            addr_ld,
  input  logic [AW-1:0]   addr_in,
  output logic [AW-1:0]   addr,
  output logic            wr_en,
  output logic [1:0]      wr_target,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            idle_slot,
  output logic            fill_start,
  output logic [DW-1:0]   fill_value
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int IW = $clog2(CRAM_WORDS);
  localparam int HW = DW / 2;

  logic [DW-1:0]    q_data [DEPTH];
  logic [CW-1:0]    q_when [DEPTH];
  logic [DEPTH-1:0] q_part;
  logic [LW-1:0]    cnt;

  logic empty, full, head_ok, serve, act, is_fill;
  logic t_vram, t_cram, t_vsram, vs_ok, vram_first, pop, bump, psh;
  logic [IW-1:0] widx;
  logic [PW-1:0] push_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == LW'(DEPTH));
  assign head_ok = !empty && (q_when[0] <= cycle_now);
  assign serve   = slot && !dma_busy;
  assign act     = serve && head_ok;
  assign is_fill = act && dma_en && cmd_dma;
  assign t_vram  = (cmd_tgt == 4'd1);
  assign t_cram  = (cmd_tgt == 4'd3);
  assign t_vsram = (cmd_tgt == 4'd5);
  assign widx    = addr[IW:1];
  assign vs_ok   = (int'(widx) < VSRAM_WORDS);

  assign vram_first = act && !is_fill && t_vram && !q_part[0];
  assign pop        = act && !vram_first;
  assign bump       = pop && !is_fill;
  assign psh        = push && !full;
  assign push_idx   = pop ? PW'(cnt - 1'b1) : PW'(cnt);

  assign wr_wait    = full;
  assign idle_slot  = serve && !head_ok;
  assign fill_start = is_fill;
  assign wr_en      = act && !is_fill && (t_vram || t_cram || (t_vsram && vs_ok));

  always_comb begin
    wr_target = 2'd0;
    wr_addr   = '0;
    wr_data   = '0;
    if (t_vram) begin
      wr_addr = {addr[AW-1:1], addr[0] ^ q_part[0]};
      wr_data = q_part[0] ? {{HW{1'b0}}, q_data[0][HW-1:0]}
                          : {{HW{1'b0}}, q_data[0][DW-1:HW]};
    end else begin
      wr_target = t_cram ? 2'd1 : 2'd2;
      wr_addr   = AW'(widx);
      wr_data   = q_data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      addr       <= '0;
      fill_value <= '0;
      q_part     <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_data[i] <= '0;
        q_when[i] <= '0;
      end
    end else begin
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          q_data[i] <= q_data[i+1];
          q_when[i] <= q_when[i+1];
          q_part[i] <= q_part[i+1];
        end
        q_data[DEPTH-1] <= '0;
        q_when[DEPTH-1] <= '0;
        q_part[DEPTH-1] <= 1'b0;
      end
      if (vram_first) q_part[0] <= 1'b1;
      if (psh) begin
        q_data[push_idx] <= push_data;
        q_when[push_idx] <= push_when;
        q_part[push_idx] <= 1'b0;
      end
      cnt <= cnt + LW'(psh) - LW'(pop);
      if (addr_ld)   addr <= addr_in;
      else if (bump) addr <= addr + AW'(autoinc);
      if (is_fill) fill_value <= q_data[0];
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH));
  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wait && push && !pop) |=> wr_wait);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle_slot |-> (!wr_en && !fill_start));
  p_vram_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_first && !addr_ld) |=> ($stable(addr) && q_part[0] && !empty));
  p_vsram_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_target == 2'd2) |-> (int'(wr_addr) < VSRAM_WORDS));
  p_pop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt == $past(cnt) - 1'b1));
  p_fill_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_start && !addr_ld) |=> $stable(addr));
  p_busy_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && dma_busy) |-> (!wr_en && !idle_slot && !fill_start));
endmodule

// File: tb/tb_wq_drain.sv
module tb_wq_drain;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, push, slot, dma_busy, dma_en, cmd_dma, addr_ld;
  logic [15:0] cycle_now, push_data, push_when, addr_in;
  logic [3:0] cmd_tgt;
  logic [7:0] autoinc;
  logic wr_wait, wr_en, idle_slot, fill_start;
  logic [1:0] wr_target;
  logic [15:0] addr, wr_addr, wr_data, fill_value;

  wq_drain dut (
    .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now), .push(push),
    .push_data(push_data), .push_when(push_when), .wr_wait(wr_wait),
    .slot(slot), .dma_busy(dma_busy), .dma_en(dma_en), .cmd_tgt(cmd_tgt),
    .cmd_dma(cmd_dma), .autoinc(autoinc), .addr_ld(addr_ld), .addr_in(addr_in),
    .addr(addr), .wr_en(wr_en), .wr_target(wr_target), .wr_addr(wr_addr),
    .wr_data(wr_data), .idle_slot(idle_slot), .fill_start(fill_start),
    .fill_value(fill_value)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] cyc = 0;

  logic [15:0] md [4];
  logic [15:0] mw [4];
  bit mp [4];
  int mn = 0;
  logic [15:0] maddr = 0, mfill = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit vs_ok_f(logic [15:0] a);
    return ((a >> 1) & 16'd63) < 16'd40;
  endfunction

  task automatic step(bit p, logic [15:0] d, logic [15:0] woff, bit s, bit busy,
                      bit den, logic [3:0] tgt, bit cdma, bit ld,
                      logic [15:0] la, logic [7:0] inc);
    bit serve, ok, act, fill, first, en, pop;
    logic [1:0] et;
    logic [15:0] ea, ed;
    push = p; push_data = d; push_when = cyc + woff; slot = s; dma_busy = busy;
    dma_en = den; cmd_tgt = tgt; cmd_dma = cdma; addr_ld = ld; addr_in = la;
    autoinc = inc; cycle_now = cyc;
    #1;
    serve = s && !busy;
    ok = (mn > 0) && (mw[0] <= cyc);
    act = serve && ok;
    fill = act && den && cdma;
    first = act && !fill && tgt == 4'd1 && !mp[0];
    en = act && !fill && (tgt == 4'd1 || tgt == 4'd3 || (tgt == 4'd5 && vs_ok_f(maddr)));
    et = 2'd0; ea = 16'd0; ed = 16'd0;
    if (tgt == 4'd1) begin
      ea = maddr ^ {15'd0, mp[0]};
      ed = mp[0] ? {8'd0, md[0][7:0]} : {8'd0, md[0][15:8]};
    end else begin
      et = (tgt == 4'd3) ? 2'd1 : 2'd2;
      ea = (maddr >> 1) & 16'd63;
      ed = md[0];
    end
    chk("R2 wr_wait", wr_wait, mn == 4);
    chk("R7/R10 addr", addr, maddr);
    chk("R8 fill_value", fill_value, mfill);
    chk(busy ? "R9 idle_slot" : "R3 idle_slot", idle_slot, serve && !ok);
    chk(busy ? "R9 fill_start" : "R8 fill_start", fill_start, fill);
    chk(tgt == 4'd5 ? "R6 wr_en" : (tgt == 4'd1 ? "R4 wr_en" : "R5/R7 wr_en"), wr_en, en);
    if (en) begin
      chk("R4/R5/R6 wr_target", wr_target, et);
      chk(tgt == 4'd1 ? "R4 wr_addr" : "R5/R6 wr_addr", wr_addr, ea);
      chk(tgt == 4'd1 ? "R4 wr_data" : "R5/R6/R7 wr_data", wr_data, ed);
    end
    pop = act && !first;
    if (fill) mfill = md[0];
    if (ld) maddr = la;
    else if (pop && !fill) maddr = maddr + {8'd0, inc};
    if (first) mp[0] = 1;
    if (pop) begin
      for (int i = 0; i < 3; i++) begin md[i] = md[i+1]; mw[i] = mw[i+1]; mp[i] = mp[i+1]; end
      mn--;
    end
    if (p && (mn + (pop ? 1 : 0)) < 4) begin
      md[mn] = d; mw[mn] = cyc + woff; mp[mn] = 0; mn++;
    end
    @(posedge clk); @(negedge clk);
    cyc++;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; push = 0; push_data = 0; push_when = 0; slot = 0; dma_busy = 0;
    dma_en = 0; cmd_tgt = 0; cmd_dma = 0; addr_ld = 0; addr_in = 0; autoinc = 0;
    cycle_now = 0;
    for (int i = 0; i < 4; i++) begin md[i] = 0; mw[i] = 0; mp[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset wr_wait", wr_wait, 0);
    chk("R1 reset addr", addr, 0);
    chk("R1 reset wr_en", wr_en, 0);
    chk("R1 reset fill_value", fill_value, 0);
    rst_n = 1;
    // R3: empty queue gives an idle slot
    step(0, 0, 0, 1, 0, 0, 4'd1, 0, 0, 0, 8'd2);
    // R2: fill to four, fifth push dropped
    for (int i = 0; i < 5; i++) step(1, 16'hA100 + 16'(i), 0, 0, 0, 0, 4'd1, 0, 0, 0, 8'd2);
    step(0, 0, 0, 0, 0, 0, 4'd1, 0, 1, 16'h1234, 8'd2);
    // R4: byte pairs in pattern memory
    for (int i = 0; i < 9; i++) step(0, 0, 0, 1, 0, 0, 4'd1, 0, 0, 0, 8'd2);
    // R3: future timestamp held back
    step(1, 16'hBEEF, 16'd6, 0, 0, 0, 4'd3, 0, 0, 0, 8'd2);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 0, 4'd3, 0, 0, 0, 8'd2);
    // R6: scroll index 40 is out of range, index 39 in range
    step(1, 16'h1111, 0, 0, 0, 0, 4'd5, 0, 1, 16'h0050, 8'd2);
    step(1, 16'h2222, 0, 0, 0, 0, 4'd5, 0, 1, 16'h004E, 8'd2);
    step(0, 0, 0, 1, 0, 0, 4'd5, 0, 0, 0, 8'd2);
    step(0, 0, 0, 1, 0, 0, 4'd5, 0, 0, 0, 8'd2);
    // R9 then R8
    step(1, 16'hF00D, 0, 0, 0, 1, 4'd1, 1, 0, 0, 8'd2);
    step(0, 0, 0, 1, 1, 1, 4'd1, 1, 0, 0, 8'd2);
    step(0, 0, 0, 1, 0, 1, 4'd1, 1, 0, 0, 8'd2);
    step(0, 0, 0, 0, 0, 0, 4'd1, 0, 0, 0, 8'd2);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] tgts [6] = '{4'd1, 4'd3, 4'd5, 4'd1, 4'd0, 4'd7};
      step($urandom_range(0, 99) < 45, 16'($urandom), 16'($urandom_range(0, 5)),
           $urandom_range(0, 99) < 55, $urandom_range(0, 99) < 10,
           $urandom_range(0, 1), tgts[$urandom_range(0, 5)],
           $urandom_range(0, 99) < 10, $urandom_range(0, 99) < 5,
           16'($urandom), 8'($urandom_range(0, 4)));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule